// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one byte, written into a single-entry transmit buffer, into an asynchronous serial character on one output line. The write also takes the frame settings in effect at that moment: whether a ninth data bit follows the byte, whether a parity bit is added and of which kind, and whether one or two stop bits close the character. The line idles high. A character starts with one low start bit, and all bits go out least significant first.

Bit timing comes from an internal tick divider, and every bit lasts a fixed count of ticks. One mode ticks on every clock. The other two modes tick once per programmable count of clocks. When the clear-to-send gate is enabled, a buffered character does not start until the active-low clear-to-send input is low. A break input, also active low, can pull the line low at any time. A sticky done flag rises halfway through the last stop bit and stays set until it is cleared. A busy output shows that the buffer is occupied.

Top module: `sertx_top`

## Requirements
- R1: After reset, txd_o is 1, busy_o is 0 and done_o is 0.
- R2: A character is one start bit (0), then wr_data_i bit 0 through bit 7. Mode 2'b00 and mode 2'b01 add bit9_i as the ninth data bit. Mode 2'b10 leaves it out.
- R3: Every bit lasts OVS (16) ticks. Mode 2'b01 ticks on every clock. Modes 2'b00 and 2'b10 tick once every baud_div_i+1 clocks, so a bit lasts 16*(baud_div_i+1) clocks.
- R4: With par_en_i=1, one parity bit follows the data bits. par_type_i selects the type: 2'b00 makes the count of ones over data and parity odd, 2'b01 makes it even, 2'b10 sends 1 and 2'b11 sends 0. With par_en_i=0 no parity bit is sent.
- R5: two_stop_i=0 sends one stop bit (1). two_stop_i=1 sends two.
- R6: While brk_n_i is 0, txd_o is 0, whatever the transmitter state. When brk_n_i returns to 1, the line goes back to its normal level.
- R7: With cts_en_i=1, a buffered character starts only while cts_ni is 0. With cts_en_i=0, cts_ni has no effect.
- R8: Once the start bit has begun, the character always completes. A change on cts_ni, or on any frame setting input, during the character does not alter it.
- R9: done_o becomes 1 halfway through the last stop bit and stays 1 until done_clr_i is 1. If setting and clearing happen in the same cycle, setting wins.
- R10: busy_o is 1 from an accepted write until the end of the last stop bit. A write while busy_o is 1 is ignored.
- R11: A write with mode_i=2'b11 is ignored: busy_o stays 0 and the line stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the transmit buffer |
| wr_data_i | input | 8 | Byte to send |
| mode_i | input | 2 | Frame and timing mode |
| bit9_i | input | 1 | Ninth data bit for the 9-bit modes |
| par_en_i | input | 1 | Parity bit enable |
| par_type_i | input | 2 | Parity type |
| two_stop_i | input | 1 | Two stop bits when 1 |
| brk_n_i | input | 1 | Break control, 0 forces the line low |
| cts_en_i | input | 1 | Clear-to-send gating enable |
| cts_ni | input | 1 | Clear-to-send, active low |
| baud_div_i | input | DIV_W | Tick divider for the baud-generator modes |
| done_clr_i | input | 1 | Clears the done flag |
| txd_o | output | 1 | Serial line out |
| busy_o | output | 1 | Buffer occupied or character in progress |
| done_o | output | 1 | Sticky character-done flag |

## Verification
The bench decodes each character at the middle of every bit, using the falling start edge and the expected bit length. It compares the result with a frame it builds from the mode, parity and stop settings. A design with the ninth bit or the parity bit out of place, the wrong parity sense, or a wrong divider would show the wrong bit in some position.

It also checks that done_o is still low at the middle of the bit before the last stop bit and high at the middle of the last one. A flag set one bit early or at the end of the frame would fail there.

Directed cases cover the following:
- A character that waits on clear-to-send. A design that ignores the gate would start at once.
- Clear-to-send and all settings changing mid-character. A design that samples them live would corrupt or abort the character.
- A write that lands while busy. A design that accepts it would overwrite the character or send a second one.
- A mode 2'b11 write. A design that accepts it would raise busy_o.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    MODE_NINE_BG  = 2'b00,
    MODE_NINE_CLK = 2'b01,
    MODE_EIGHT_BG = 2'b10,
    MODE_SHIFT    = 2'b11
  } tx_mode_e;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_type_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_SEND = 2'b10
  } tx_state_e;

  // start + 8 data + ninth + parity + 2 stop
  localparam int unsigned FRAME_W = 13;
  localparam int unsigned LEN_W   = 4;
endpackage

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
(
  input  logic [7:0]         data_i,
  input  logic               bit9_i,
  input  logic [1:0]         mode_i,
  input  logic               par_en_i,
  input  logic [1:0]         par_type_i,
  input  logic               two_stop_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o
);
  logic       nine;
  logic       ones;
  logic       par_bit;
  logic [3:0] pos;

  assign nine = (mode_i == MODE_NINE_BG) || (mode_i == MODE_NINE_CLK);
  assign ones = (^data_i) ^ (nine & bit9_i);

  always_comb begin
    unique case (par_type_i)
      PAR_ODD:  par_bit = ~ones;
      PAR_EVEN: par_bit = ones;
      PAR_MARK: par_bit = 1'b1;
      default:  par_bit = 1'b0;
    endcase
  end

  // unused tail stays at idle level
  always_comb begin
    frame_o      = '1;
    frame_o[0]   = 1'b0;
    frame_o[8:1] = data_i;
    pos          = 4'd9;
    if (nine) begin
      frame_o[pos] = bit9_i;
      pos          = pos + 4'd1;
    end
    if (par_en_i) begin
      frame_o[pos] = par_bit;
      pos          = pos + 4'd1;
    end
    len_o = pos + (two_stop_i ? 4'd2 : 4'd1);
  end
endmodule

// File: rtl/sertx_tick.sv
module sertx_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] lim_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == lim_i);

  // phase restarts at every character
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned OVS   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_ok_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [DIV_W-1:0]   lim_i,
  input  logic               cts_en_i,
  input  logic               cts_ni,
  input  logic               done_clr_i,
  input  logic               tick_i,
  output logic               run_o,
  output logic [DIV_W-1:0]   lim_o,
  output logic               line_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int unsigned SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

  tx_state_e          state_q;
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   left_q;
  logic [SUB_W-1:0]   sub_q;
  logic [DIV_W-1:0]   lim_q;
  logic               done_q;
  logic               last_bit;
  logic               may_go;

  assign last_bit = (left_q == LEN_W'(1));
  assign may_go   = !cts_en_i || !cts_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '1;
      left_q  <= '0;
      sub_q   <= '0;
      lim_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_ok_i) begin
          sh_q    <= frame_i;
          left_q  <= len_i;
          lim_q   <= lim_i;
          sub_q   <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (may_go) state_q <= ST_SEND;
        ST_SEND: if (tick_i) begin
          if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            if (last_bit) begin
              state_q <= ST_IDLE;
            end else begin
              sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
              left_q <= left_q - 1'b1;
            end
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      done_q <= 1'b0;
    else if ((state_q == ST_SEND) && tick_i && last_bit && (sub_q == SUB_MID))
      done_q <= 1'b1;
    else if (done_clr_i)
      done_q <= 1'b0;
  end

  assign run_o  = (state_q == ST_SEND);
  assign lim_o  = lim_q;
  assign line_o = (state_q == ST_SEND) ? sh_q[0] : 1'b1;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned OVS   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic [1:0]       mode_i,
  input  logic             bit9_i,
  input  logic             par_en_i,
  input  logic [1:0]       par_type_i,
  input  logic             two_stop_i,
  input  logic             brk_n_i,
  input  logic             cts_en_i,
  input  logic             cts_ni,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             done_clr_i,
  output logic             txd_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic [DIV_W-1:0]   lim_new;
  logic [DIV_W-1:0]   lim_run;
  logic               load_ok;
  logic               run;
  logic               tick;
  logic               line;

  assign load_ok = wr_en_i && !busy_o && (mode_i != MODE_SHIFT);
  assign lim_new = (mode_i == MODE_NINE_CLK) ? '0 : baud_div_i;

  sertx_frame u_frame (
    .data_i     (wr_data_i),
    .bit9_i     (bit9_i),
    .mode_i     (mode_i),
    .par_en_i   (par_en_i),
    .par_type_i (par_type_i),
    .two_stop_i (two_stop_i),
    .frame_o    (frame),
    .len_o      (len)
  );

  sertx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .lim_i  (lim_run),
    .tick_o (tick)
  );

  sertx_shift #(.DIV_W(DIV_W), .OVS(OVS)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_ok_i  (load_ok),
    .frame_i    (frame),
    .len_i      (len),
    .lim_i      (lim_new),
    .cts_en_i   (cts_en_i),
    .cts_ni     (cts_ni),
    .done_clr_i (done_clr_i),
    .tick_i     (tick),
    .run_o      (run),
    .lim_o      (lim_run),
    .line_o     (line),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  assign txd_o = line & brk_n_i;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       mode_i,
  input logic             brk_n_i,
  input logic             done_clr_i,
  input logic [DIV_W-1:0] baud_div_i,
  input logic             txd_o,
  input logic             busy_o,
  input logic             done_o
);
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && brk_n_i) |-> txd_o);

  assert_break_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brk_n_i |-> !txd_o);

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !done_clr_i) |=> done_o);

  assert_done_in_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> busy_o);

  assert_shift_mode_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_en_i && (mode_i == 2'b11)) |=> !busy_o);

  assert_write_starts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_en_i && (mode_i != 2'b11)) |=> busy_o);

  logic unused_ok;
  assign unused_ok = ^baud_div_i;
endmodule

bind sertx_top sertx_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [7:0]       wr_data_i = '0;
  logic [1:0]       mode_i = 2'b00;
  logic             bit9_i = 1'b0;
  logic             par_en_i = 1'b0;
  logic [1:0]       par_type_i = 2'b00;
  logic             two_stop_i = 1'b0;
  logic             brk_n_i = 1'b1;
  logic             cts_en_i = 1'b0;
  logic             cts_ni = 1'b1;
  logic [DIV_W-1:0] baud_div_i = '0;
  logic             done_clr_i = 1'b0;
  logic             txd_o, busy_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sertx_top #(.DIV_W(DIV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .mode_i(mode_i), .bit9_i(bit9_i), .par_en_i(par_en_i), .par_type_i(par_type_i),
    .two_stop_i(two_stop_i), .brk_n_i(brk_n_i), .cts_en_i(cts_en_i), .cts_ni(cts_ni),
    .baud_div_i(baud_div_i), .done_clr_i(done_clr_i),
    .txd_o(txd_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [12:0] exp_frame(input logic [7:0] d, input logic b9,
      input logic [1:0] m, input logic pe, input logic [1:0] pt, input logic ts,
      output int n);
    logic [12:0] f;
    logic ones;
    f = '1;
    f[0] = 1'b0;
    f[8:1] = d;
    n = 9;
    ones = ^d;
    if (m != 2'b10) begin
      f[n] = b9;
      n++;
      ones ^= b9;
    end
    if (pe) begin
      case (pt)
        2'b00: f[n] = ~ones;
        2'b01: f[n] = ones;
        2'b10: f[n] = 1'b1;
        default: f[n] = 1'b0;
      endcase
      n++;
    end
    n += ts ? 2 : 1;
    return f;
  endfunction

  task automatic set_cfg(input logic [1:0] m, input logic b9, input logic pe,
                         input logic [1:0] pt, input logic ts, input logic [7:0] dv);
    mode_i = m; bit9_i = b9; par_en_i = pe; par_type_i = pt; two_stop_i = ts;
    baud_div_i = dv;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_data_i = d;
    wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic clear_done;
    @(negedge clk);
    done_clr_i = 1'b1;
    @(negedge clk);
    done_clr_i = 1'b0;
  endtask

  // disturb: 1 = flip cts and all settings after start; 2 = write while busy
  task automatic rx_check(input logic [12:0] ef, input int en, input int l,
                          input int disturb, input string tag);
    logic [12:0] got;
    logic done_pre, done_mid;
    int w;
    got = '1; w = 0; done_pre = 1'b0; done_mid = 1'b0;
    while (txd_o !== 1'b0 && w < 4000) begin
      @(negedge clk);
      w++;
    end
    if (w >= 4000) begin
      check(1'b0, {tag, " R2 no start bit"}, 32'(txd_o), 0);
      return;
    end
    if (disturb == 1) begin
      cts_ni = 1'b1;
      mode_i = ~mode_i; par_type_i = ~par_type_i; par_en_i = ~par_en_i;
      two_stop_i = ~two_stop_i; baud_div_i = baud_div_i + 8'd3;
    end
    repeat (8 * l) @(negedge clk);
    for (int k = 0; k < en; k++) begin
      if (k > 0) begin
        if (disturb == 2 && k == 3) begin
          wr_data_i = ~wr_data_i;
          wr_en_i = 1'b1;
          @(negedge clk);
          wr_en_i = 1'b0;
          repeat (16 * l - 1) @(negedge clk);
        end else begin
          repeat (16 * l) @(negedge clk);
        end
      end
      got[k] = txd_o;
      if (k == en - 2) done_pre = done_o;
      if (k == en - 1) done_mid = done_o;
    end
    check(got == ef, {tag, " R2 R3 R4 R5 R8 frame"}, 32'(got), 32'(ef));
    check(!done_pre && done_mid, {tag, " R9 done at last stop middle"},
          {30'd0, done_pre, done_mid}, 32'h1);
    repeat (8 * l) @(negedge clk);
    check(!busy_o && txd_o, {tag, " R10 busy ends after stop"},
          {30'd0, busy_o, txd_o}, 32'h1);
  endtask

  task automatic frame_run(input logic [7:0] d, input logic b9, input logic [1:0] m,
      input logic pe, input logic [1:0] pt, input logic ts, input logic [7:0] dv,
      input int disturb, input string tag);
    logic [12:0] ef;
    int en, l;
    ef = exp_frame(d, b9, m, pe, pt, ts, en);
    l = (m == 2'b01) ? 1 : int'(dv) + 1;
    set_cfg(m, b9, pe, pt, ts, dv);
    clear_done;
    write_byte(d);
    rx_check(ef, en, l, disturb, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_7a11));
    repeat (3) @(negedge clk);
    check(txd_o && !busy_o && !done_o, "R1 reset state",
          {29'd0, txd_o, busy_o, done_o}, 32'h4);
    rst_ni = 1'b1;
    @(negedge clk);
    check(txd_o && !busy_o && !done_o, "R1 after reset release",
          {29'd0, txd_o, busy_o, done_o}, 32'h4);

    // directed: each mode, each parity, stop counts
    frame_run(8'hA5, 1'b1, 2'b01, 1'b0, 2'b00, 1'b0, 8'd0, 0, "R2 R3 mode01 nine");
    frame_run(8'h3C, 1'b0, 2'b10, 1'b0, 2'b00, 1'b1, 8'd1, 0, "R3 R5 mode10 two stop");
    frame_run(8'h81, 1'b1, 2'b00, 1'b1, 2'b00, 1'b0, 8'd2, 0, "R4 odd");
    frame_run(8'h81, 1'b1, 2'b00, 1'b1, 2'b01, 1'b0, 8'd0, 0, "R4 even");
    frame_run(8'h00, 1'b0, 2'b10, 1'b1, 2'b10, 1'b1, 8'd0, 0, "R4 mark");
    frame_run(8'hFF, 1'b1, 2'b01, 1'b1, 2'b11, 1'b1, 8'd5, 0, "R4 space");

    // random frames
    for (int i = 0; i < 24; i++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 2));
      frame_run(8'($urandom), 1'($urandom), m, 1'($urandom), 2'($urandom),
                1'($urandom), 8'($urandom_range(0, 3)), 0, "rand");
    end

    // R7: gated by cts
    cts_en_i = 1'b1;
    cts_ni = 1'b1;
    set_cfg(2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 8'd0);
    clear_done;
    write_byte(8'h5A);
    repeat (60) @(negedge clk);
    check(txd_o && busy_o, "R7 held by cts", {30'd0, txd_o, busy_o}, 32'h3);
    begin
      logic [12:0] ef;
      int en;
      ef = exp_frame(8'h5A, 1'b0, 2'b10, 1'b0, 2'b00, 1'b0, en);
      cts_ni = 1'b0;
      // R8: cts released and settings changed mid-character
      rx_check(ef, en, 1, 1, "R7 R8 cts release");
    end

    // R7: cts ignored when gate disabled
    cts_en_i = 1'b0;
    cts_ni = 1'b1;
    frame_run(8'hC3, 1'b1, 2'b01, 1'b1, 2'b01, 1'b0, 8'd0, 0, "R7 gate off");

    // R10: write while busy ignored
    frame_run(8'h96, 1'b0, 2'b01, 1'b0, 2'b00, 1'b0, 8'd0, 2, "R10 write busy");
    repeat (80) @(negedge clk);
    check(txd_o && !busy_o, "R10 no second character", {30'd0, txd_o, busy_o}, 32'h2);

    // R9: sticky then cleared
    check(done_o, "R9 done sticky", 32'(done_o), 1);
    clear_done;
    check(!done_o, "R9 done cleared", 32'(done_o), 0);

    // R11: shift mode ignored
    mode_i = 2'b11;
    write_byte(8'h11);
    repeat (40) @(negedge clk);
    check(!busy_o && txd_o, "R11 mode 11 ignored", {30'd0, busy_o, txd_o}, 32'h1);

    // R6: break while idle and during a character
    brk_n_i = 1'b0;
    @(negedge clk);
    check(!txd_o, "R6 break idle", 32'(txd_o), 0);
    brk_n_i = 1'b1;
    @(negedge clk);
    check(txd_o, "R6 break release", 32'(txd_o), 1);
    set_cfg(2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 8'd0);
    write_byte(8'hFF);
    repeat (40) @(negedge clk);
    brk_n_i = 1'b0;
    @(negedge clk);
    check(!txd_o && busy_o, "R6 break in character", {30'd0, txd_o, busy_o}, 32'h1);
    brk_n_i = 1'b1;
    @(negedge clk);
    check(txd_o, "R6 data bit back after break", 32'(txd_o), 1);
    repeat (300) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule